// File: doc/BRIEF.md
# CAN Remote Frame Auto-Responder

This block answers CAN remote frames without software help. A receive path that has already decoded a remote frame presents its identifier, its extended-format flag and a one-cycle strobe. The block compares that identifier with every buffer in a bank of transmit message buffers. From the buffers that qualify, it selects one and raises a transmit request toward the serializer. The request carries the chosen buffer's index, identifier, format flag and payload.

Only buffers that software has marked with the reply code take part. The comparison is exact, and no acceptance mask is applied. A received remote frame is never stored: its only effect is the reply it may trigger. The stored RTR bit of the matched buffer decides the reply type. A clear bit gives a data frame. A set bit makes the block answer with a remote frame of its own. Software fills the bank through a simple write port, one buffer per write.

Top module: `canRemoteResponder`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, txReq is low.
- R2: Only a buffer whose 4-bit code field holds 4'b1010 can match. Any other code value never produces a request.
- R3: Matching is exact and uses no mask. With rxIde=1 all 29 ID bits must be equal. With rxIde=0 only ID bits [10:0] are compared, and bits [28:11] of rxId are don't-care.
- R4: The stored IDE flag must equal rxIde, so a standard frame never matches an extended buffer with the same low bits.
- R5: When several buffers match, the one with the lowest index is chosen.
- R6: A match on a buffer whose RTR bit is clear gives txRemote=0. txId, txIde and txData then present that buffer's stored contents.
- R7: A match on a buffer whose RTR bit is set gives txRemote=1.
- R8: A remote frame that matches no buffer raises no request.
- R9: txReq stays high until a cycle in which txAccept is high, and it is low in the following cycle.
- R10: Remote-frame strobes that arrive while a request is pending are ignored and raise no second request.
- R11: The reply outputs are fixed when the match is taken. Buffer writes made while the request is pending do not change txBufIdx, txRemote, txId, txIde or txData.
- R12: A strobe that matches, sampled on a clock edge while the block is idle, makes txReq high right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Write one buffer this cycle |
| cfgIdx | input | IDX_W | Index of the buffer to write |
| cfgCode | input | 4 | Code field to store |
| cfgId | input | 29 | Identifier to store (standard IDs in bits [10:0]) |
| cfgIde | input | 1 | Extended-format flag to store |
| cfgRtr | input | 1 | RTR bit to store (1 = reply as remote frame) |
| cfgData | input | DATA_W | Payload to store |
| rxRemoteStb | input | 1 | One-cycle strobe: a remote frame was received |
| rxId | input | 29 | Identifier of the received remote frame |
| rxIde | input | 1 | Extended-format flag of the received frame |
| txAccept | input | 1 | One-cycle pulse from the transmitter taking the request |
| txReq | output | 1 | Reply pending |
| txBufIdx | output | IDX_W | Index of the chosen buffer |
| txRemote | output | 1 | 1 = send reply as remote frame, 0 = data frame |
| txId | output | 29 | Identifier of the reply |
| txIde | output | 1 | Extended-format flag of the reply |
| txData | output | DATA_W | Payload of the reply |

## Verification
The assertions assume two things. First, rxRemoteStb is a strobe that a decoded frame produces. Second, txAccept is pulsed only while txReq is high, so a request is never accepted before it exists. The stimulus keeps to this because the transmitter model in the bench raises txAccept only after it has seen txReq. It also keeps rxId and rxIde steady for the whole cycle in which the strobe is high. Buffer writes and strobes go in at the falling edge, so each rising edge sees settled values.

// File: rtl/canRespPkg.sv
package canRespPkg;
  localparam int ID_W     = 29;
  localparam int STD_ID_W = 11;
  localparam int CODE_W   = 4;
  localparam logic [CODE_W-1:0] CODE_AUTO_REPLY = 4'b1010;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // capture the selected buffer as the pending reply
  } ctrlStrobeT;
endpackage

// File: rtl/canRespDatapath.sv
module canRespDatapath
  import canRespPkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [CODE_W-1:0] cfgCode,
  input  logic [ID_W-1:0]   cfgId,
  input  logic              cfgIde,
  input  logic              cfgRtr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [ID_W-1:0]   rxId,
  input  logic              rxIde,
  input  ctrlStrobeT        strb,
  output logic              anyHit,
  output logic [IDX_W-1:0]  txBufIdx,
  output logic              txRemote,
  output logic [ID_W-1:0]   txId,
  output logic              txIde,
  output logic [DATA_W-1:0] txData
);

  // Message buffer bank
  logic [CODE_W-1:0] codeQ [NUM_BUF];
  logic [ID_W-1:0]   idQ   [NUM_BUF];
  logic              ideQ  [NUM_BUF];
  logic              rtrQ  [NUM_BUF];
  logic [DATA_W-1:0] dataQ [NUM_BUF];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_BUF; i++) begin
        codeQ[i] <= '0;
        idQ[i]   <= '0;
        ideQ[i]  <= 1'b0;
        rtrQ[i]  <= 1'b0;
        dataQ[i] <= '0;
      end
    end else if (cfgWrEn && (int'(cfgIdx) < NUM_BUF)) begin
      codeQ[cfgIdx] <= cfgCode;
      idQ[cfgIdx]   <= cfgId;
      ideQ[cfgIdx]  <= cfgIde;
      rtrQ[cfgIdx]  <= cfgRtr;
      dataQ[cfgIdx] <= cfgData;
    end
  end

  // Per-buffer comparators
  logic [NUM_BUF-1:0] hitVec;

  for (genvar g = 0; g < NUM_BUF; g++) begin : gCmp
    logic idEq;
    logic codeOk;
    assign codeOk = (codeQ[g] == CODE_AUTO_REPLY);
    assign idEq   = rxIde ? (idQ[g] == rxId)
                          : (idQ[g][STD_ID_W-1:0] == rxId[STD_ID_W-1:0]);
    assign hitVec[g] = codeOk && (ideQ[g] == rxIde) && idEq;
  end

  // Lowest index wins
  logic [IDX_W-1:0] selIdx;
  always_comb begin
    selIdx = '0;
    for (int i = NUM_BUF - 1; i >= 0; i--) begin
      if (hitVec[i]) selIdx = IDX_W'(i);
    end
  end
  assign anyHit = |hitVec;

  // Snapshot of the pending reply
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBufIdx <= '0;
      txRemote <= 1'b0;
      txId     <= '0;
      txIde    <= 1'b0;
      txData   <= '0;
    end else if (strb.load) begin
      txBufIdx <= selIdx;
      txRemote <= rtrQ[selIdx];
      txId     <= idQ[selIdx];
      txIde    <= ideQ[selIdx];
      txData   <= dataQ[selIdx];
    end
  end

endmodule

// File: rtl/canRespControl.sv
module canRespControl
  import canRespPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rxRemoteStb,
  input  logic       anyHit,
  input  logic       txAccept,
  output ctrlStrobeT strb,
  output logic       txReq
);

  typedef enum logic {ST_IDLE, ST_PEND} stateT;
  stateT state, stateNxt;

  always_comb begin
    stateNxt  = state;
    strb.load = 1'b0;
    unique case (state)
      ST_IDLE: if (rxRemoteStb && anyHit) begin
        strb.load = 1'b1;
        stateNxt  = ST_PEND;
      end
      ST_PEND: if (txAccept) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  assign txReq = (state == ST_PEND);

endmodule

// File: rtl/canRemoteResponder.sv
module canRemoteResponder
  import canRespPkg::*;
#(
  parameter int NUM_BUF = 8,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [3:0]        cfgCode,
  input  logic [28:0]       cfgId,
  input  logic              cfgIde,
  input  logic              cfgRtr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              rxRemoteStb,
  input  logic [28:0]       rxId,
  input  logic              rxIde,
  input  logic              txAccept,
  output logic              txReq,
  output logic [IDX_W-1:0]  txBufIdx,
  output logic              txRemote,
  output logic [28:0]       txId,
  output logic              txIde,
  output logic [DATA_W-1:0] txData
);

  ctrlStrobeT strb;
  logic       anyHit;

  canRespDatapath #(.NUM_BUF(NUM_BUF), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN),
    .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx), .cfgCode(cfgCode), .cfgId(cfgId),
    .cfgIde(cfgIde), .cfgRtr(cfgRtr), .cfgData(cfgData),
    .rxId(rxId), .rxIde(rxIde), .strb(strb), .anyHit(anyHit),
    .txBufIdx(txBufIdx), .txRemote(txRemote), .txId(txId),
    .txIde(txIde), .txData(txData)
  );

  canRespControl u_ctl (
    .clk(clk), .rstN(rstN), .rxRemoteStb(rxRemoteStb), .anyHit(anyHit),
    .txAccept(txAccept), .strb(strb), .txReq(txReq)
  );

endmodule

// File: rtl/canRespChecker.sv
module canRespChecker #(
  parameter int NUM_BUF = 8,
  parameter int DATA_W  = 64,
  localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxRemoteStb,
  input logic              txAccept,
  input logic              txReq,
  input logic [IDX_W-1:0]  txBufIdx,
  input logic              txRemote,
  input logic [28:0]       txId,
  input logic              txIde,
  input logic [DATA_W-1:0] txData
);

  // R1: reset clears the request
  assert_reset_idle_R1: assert property (@(posedge clk) !rstN |=> !txReq);

  // R9: request held until accepted
  assert_hold_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txAccept |=> txReq);

  // R9: request drops after accept
  assert_drop_req_R9: assert property (@(posedge clk) disable iff (!rstN)
    txReq && txAccept |=> !txReq);

  // R11: reply fields frozen while pending
  assert_frozen_reply_R11: assert property (@(posedge clk) disable iff (!rstN)
    txReq && !txAccept |=> $stable(txBufIdx) && $stable(txRemote)
                           && $stable(txId) && $stable(txIde) && $stable(txData));

  // R12: a new request only follows a received strobe
  assert_cause_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txReq) |-> $past(rxRemoteStb));

  // R10: strobe during pending leaves the selection alone
  assert_ignore_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    txReq && rxRemoteStb && !txAccept |=> $stable(txBufIdx));

  // R5: the index refers to an existing buffer
  assert_idx_range_R5: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> (int'(txBufIdx) < NUM_BUF));

endmodule

bind canRemoteResponder canRespChecker #(.NUM_BUF(NUM_BUF), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/canRemoteResponder_tb.sv
`timescale 1ns/1ps
module canRemoteResponder_tb;
  localparam int NUM_BUF = 8;
  localparam int DATA_W  = 64;
  localparam int IDX_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [IDX_W-1:0] cfgIdx = '0;
  logic [3:0] cfgCode = '0;
  logic [28:0] cfgId = '0;
  logic cfgIde = 1'b0, cfgRtr = 1'b0;
  logic [DATA_W-1:0] cfgData = '0;
  logic rxRemoteStb = 1'b0;
  logic [28:0] rxId = '0;
  logic rxIde = 1'b0;
  logic txAccept = 1'b0;
  logic txReq, txRemote, txIde;
  logic [IDX_W-1:0] txBufIdx;
  logic [28:0] txId;
  logic [DATA_W-1:0] txData;

  always #4 clk = ~clk;

  canRemoteResponder #(.NUM_BUF(NUM_BUF), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIdx(cfgIdx),
    .cfgCode(cfgCode), .cfgId(cfgId), .cfgIde(cfgIde), .cfgRtr(cfgRtr),
    .cfgData(cfgData), .rxRemoteStb(rxRemoteStb), .rxId(rxId), .rxIde(rxIde),
    .txAccept(txAccept), .txReq(txReq), .txBufIdx(txBufIdx),
    .txRemote(txRemote), .txId(txId), .txIde(txIde), .txData(txData)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;
  int acceptDelay = 0;

  typedef struct {
    int idx; bit remote; logic [28:0] id; bit ide; logic [DATA_W-1:0] data; string req;
  } expT;
  expT sb[$];

  // Bench model of the buffer bank
  logic [3:0]        mCode [NUM_BUF];
  logic [28:0]       mId   [NUM_BUF];
  bit                mIde  [NUM_BUF];
  bit                mRtr  [NUM_BUF];
  logic [DATA_W-1:0] mData [NUM_BUF];

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit findMatch(logic [28:0] id, bit ide, output int idx);
    idx = -1;
    for (int i = 0; i < NUM_BUF; i++) begin
      bit idOk;
      idOk = ide ? (mId[i] == id) : (mId[i][10:0] == id[10:0]);
      if (idx < 0 && mCode[i] == 4'b1010 && mIde[i] == ide && idOk) idx = i;
    end
    return idx >= 0;
  endfunction

  task automatic writeBuf(int idx, logic [3:0] code, logic [28:0] id, bit ide, bit rtr,
                          logic [DATA_W-1:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIdx = IDX_W'(idx); cfgCode = code; cfgId = id;
    cfgIde = ide; cfgRtr = rtr; cfgData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mCode[idx] = code; mId[idx] = id; mIde[idx] = ide; mRtr[idx] = rtr; mData[idx] = data;
  endtask

  task automatic pulseStrobe(logic [28:0] id, bit ide);
    rxRemoteStb = 1'b1; rxId = id; rxIde = ide;
    @(negedge clk);
    rxRemoteStb = 1'b0;
  endtask

  task automatic waitIdle();
    while (sb.size() != 0 || txReq) @(negedge clk);
  endtask

  // Driver: push the expected reply, then send the remote frame
  task automatic sendRemote(logic [28:0] id, bit ide, string req);
    int idx;
    bit hit;
    expT e;
    hit = findMatch(id, ide, idx);
    @(negedge clk);
    if (hit) begin
      e.idx = idx; e.remote = mRtr[idx]; e.id = mId[idx]; e.ide = mIde[idx];
      e.data = mData[idx]; e.req = req;
      sb.push_back(e);
    end
    pulseStrobe(id, ide);
    check(txReq == hit, "R12", "request right after strobe edge", 64'(txReq), 64'(hit));
    if (!hit) begin
      for (int k = 0; k < 3; k++) begin
        check(!txReq, req, "no request expected", 64'(txReq), 64'd0);
        @(negedge clk);
      end
    end
    waitIdle();
  endtask

  // Monitor: transmitter model and scoreboard compare
  initial begin
    expT e;
    forever begin
      @(negedge clk);
      if (rstN && txReq && !finished) begin
        if (sb.size() == 0) begin
          check(1'b0, "R10", "unexpected request", 64'(txReq), 64'd0);
          txAccept = 1'b1; @(negedge clk); txAccept = 1'b0;
        end else begin
          e = sb.pop_front();
          check(int'(txBufIdx) == e.idx, e.req, "buffer index", 64'(txBufIdx), 64'(e.idx));
          check(txRemote == e.remote, e.req, "reply type", 64'(txRemote), 64'(e.remote));
          check(txId == e.id, e.req, "reply id", 64'(txId), 64'(e.id));
          check(txIde == e.ide, e.req, "reply ide", 64'(txIde), 64'(e.ide));
          check(txData == e.data, e.req, "reply data", txData, e.data);
          for (int k = 0; k < acceptDelay; k++) begin
            @(negedge clk);
            check(txReq, "R9", "request held", 64'(txReq), 64'd1);
            check(txData == e.data && int'(txBufIdx) == e.idx, "R11", "reply frozen",
                  txData, e.data);
          end
          txAccept = 1'b1;
          @(negedge clk);
          txAccept = 1'b0;
          check(!txReq, "R9", "request dropped after accept", 64'(txReq), 64'd0);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_BUF; i++) begin
      mCode[i] = '0; mId[i] = '0; mIde[i] = 0; mRtr[i] = 0; mData[i] = '0;
    end
    repeat (3) @(negedge clk);
    check(!txReq, "R1", "reset request", 64'(txReq), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!txReq, "R1", "request after reset", 64'(txReq), 64'd0);

    writeBuf(0, 4'b1010, 29'h1ABCDE12, 1, 0, 64'hA0A1A2A3A4A5A6A7);
    writeBuf(1, 4'b1000, 29'h155,      0, 0, 64'h1111);
    writeBuf(2, 4'b0100, 29'h1ABCDE12, 1, 0, 64'h2222);
    writeBuf(3, 4'b1010, 29'h2A0,      0, 0, 64'hB0B1B2B3B4B5B6B7);
    writeBuf(4, 4'b1010, 29'h123,      1, 0, 64'hC0C1);
    writeBuf(5, 4'b1010, 29'h2A0,      0, 1, 64'hD0D1);
    writeBuf(6, 4'b1010, 29'h7FF,      0, 1, 64'hE0E1);

    sendRemote(29'h1ABCDE12, 1, "R6");               // extended data reply, buffer 0
    sendRemote(29'h155, 0, "R2");                    // code 1000: no reply
    sendRemote(29'h1ABCDE13, 1, "R3");               // one bit off: no reply
    sendRemote({18'h3FFFF, 11'h2A0}, 0, "R3");       // upper bits ignored in standard
    sendRemote(29'h123, 0, "R4");                    // standard vs extended buffer
    sendRemote(29'h123, 1, "R4");                    // extended match on buffer 4
    sendRemote(29'h2A0, 0, "R5");                    // buffers 3 and 5: lowest wins
    sendRemote(29'h7FF, 0, "R7");                    // RTR set: remote reply
    sendRemote(29'h0AA, 0, "R8");                    // nothing matches

    // Pending request: extra strobe ignored, writes do not disturb reply
    acceptDelay = 4;
    begin
      int idx;
      expT e;
      void'(findMatch(29'h1ABCDE12, 1, idx));
      @(negedge clk);
      e.idx = idx; e.remote = mRtr[idx]; e.id = mId[idx]; e.ide = mIde[idx];
      e.data = mData[idx]; e.req = "R10";
      sb.push_back(e);
      pulseStrobe(29'h1ABCDE12, 1);
      pulseStrobe(29'h2A0, 0);                        // R10: ignored while pending
      writeBuf(0, 4'b1010, 29'h1ABCDE12, 1, 1, 64'h5555);  // R11
      waitIdle();
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(!txReq, "R10", "no second request", 64'(txReq), 64'd0);
      end
    end
    acceptDelay = 0;

    sendRemote(29'h1ABCDE12, 1, "R7");               // rewritten buffer 0 now RTR
    writeBuf(3, 4'b0000, 29'h2A0, 0, 0, 64'h0);
    sendRemote(29'h2A0, 0, "R5");                    // buffer 5 after 3 deactivated

    repeat (3) @(negedge clk);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule